// File: doc/BRIEF.md
# Multi-Level Trigger Sequence Emulator

This block stands in for the central trigger processor when a local trigger unit must drive its front end on its own. It holds a small program of sequence entries. Each time a start event is accepted it plays the next entry as a burst of timed pulses: an optional pre-pulse, a level-0 pulse, an optional level-1 pulse carrying a data word, and a level-2 strobe that carries an accept or reject flag and its own data word. All pulse times are counted from the accepted start in clock cycles, using three latency inputs. At a 40 MHz clock the nominal settings are 48, 260 and 3520 cycles.

Start events come from four sources, each with its own enable bit: a programmable clock divider, a 32-bit pseudo-random generator compared against a threshold, the rising edge of an external pulser line, and a software request. While a sequence is playing, the block accepts no new start. So no second level-0 can appear before the pending level-1 time. Starts that arrive then are dropped and counted. Program entries can also ask for a deliberate protocol error, to exercise the recovery logic of a front end. A global enable input arms these errors.

Top module: `trig_seq_emulator`

## Requirements
- R1: After reset all pulse outputs, `busy_o`, both data outputs and `drop_cnt_o` are 0.
- R2: An entry word has the kind in bits [2:0], the error field in bits [4:3], the level-1 word in bits [20:5] and the level-2 word in bits [36:21]. Entries play in index order 0 .. `prog_len`-1 and then wrap to 0. If `prog_len` is 0 or 1, entry 0 plays every time.
- R3: `src_en` bit 0 enables the divider, which gives one start every `div_period` cycles (0 stops it). Bit 1 enables the random source, which starts when the generator value is below `rnd_thresh` (0 never starts). Bit 2 enables a start on each rising edge of `ext_pulse`. Bit 3 enables `sw_req`. A source whose bit is clear has no effect. Sources that coincide give one start.
- R4: A start is accepted at a clock edge; the next cycle is offset 0. The pre-pulse comes at offset 0, level-0 at `lat_l0`, level-1 at `lat_l1` and the level-2 strobe at `lat_l2`. Each is one cycle wide. The latencies must satisfy 0 < `lat_l0` < `lat_l1` < `lat_l2`.
- R5: The kind codes are: 0 L0,L1,L2-accept; 1 L0,L1,L2-reject; 2 and 3 the same as 0 and 1 with a pre-pulse; 4 L0 only; 5 pre-pulse and L0; 6 pre-pulse only; 7 no pulses.
- R6: Kinds 4 and 5 (level-1 rejected) produce neither a level-1 pulse nor a level-2 strobe. Kinds 0 to 3 always produce a level-2 strobe. `l2_acc_o` is 1 only in a strobe cycle that carries an accept.
- R7: `busy_o` is high from offset 0 through the end offset. The end offset is `lat_l2` for kinds 0 to 3 and `lat_l1` otherwise. No new sequence starts while `busy_o` is high.
- R8: A start that arrives while busy is dropped. It adds 1 to the saturating `drop_cnt_o`, does not advance the program index and does not disturb the running sequence.
- R9: When `err_en` is 1 and the kind is 0 to 3, the error field changes the sequence: 1 removes level-2, 2 removes level-1 but keeps level-2, and 3 inverts the accept flag. When `err_en` is 0, or for any other kind, the sequence plays as its kind states.
- R10: `l1_data_o` shows the entry's level-1 word during the level-1 pulse and is 0 otherwise. `l2_data_o` shows the level-2 word during the strobe and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_we | input | 1 | Program entry write enable |
| prog_addr | input | 5 | Program entry write address |
| prog_wdata | input | 37 | Program entry word |
| prog_len | input | 6 | Number of valid entries |
| src_en | input | 4 | Start source enables |
| div_period | input | 16 | Divider period in cycles |
| rnd_thresh | input | 32 | Random start threshold |
| ext_pulse | input | 1 | External pulser line |
| sw_req | input | 1 | Software start request |
| err_en | input | 1 | Error injection enable |
| lat_l0 | input | 12 | Level-0 offset |
| lat_l1 | input | 12 | Level-1 offset |
| lat_l2 | input | 12 | Level-2 offset |
| pp_o | output | 1 | Pre-pulse |
| l0_o | output | 1 | Level-0 pulse |
| l1_o | output | 1 | Level-1 pulse |
| l1_data_o | output | 16 | Level-1 data word |
| l2_stb_o | output | 1 | Level-2 message strobe |
| l2_acc_o | output | 1 | Level-2 accept flag |
| l2_data_o | output | 16 | Level-2 data word |
| busy_o | output | 1 | Sequence in progress |
| drop_cnt_o | output | 16 | Dropped start count |

## Verification
The assertions check on every cycle that:
- at most one pulse line is high and each level-0 pulse lasts one cycle;
- every level-1 pulse and level-2 strobe follows a level-0 pulse of the same sequence;
- a start that arrives while busy increments the drop count and leaves the program index unchanged;
- a divider tick is never followed by another tick the next cycle.

Only the bench scenarios can show that each kind, error code and enable setting gives the exact pulse offsets and data words, that the program index wraps, and that each start source and its enable bit behave as stated.

// File: rtl/tse_pkg.sv
package tse_pkg;

  typedef enum logic [2:0] {
    KIND_FULL_ACC    = 3'd0,
    KIND_FULL_REJ    = 3'd1,
    KIND_PP_FULL_ACC = 3'd2,
    KIND_PP_FULL_REJ = 3'd3,
    KIND_L1_REJ      = 3'd4,
    KIND_PP_L1_REJ   = 3'd5,
    KIND_PP_ONLY     = 3'd6,
    KIND_NONE        = 3'd7
  } seq_kind_e;

  typedef enum logic [1:0] {
    FAULT_NONE    = 2'd0,
    FAULT_DROP_L2 = 2'd1,
    FAULT_DROP_L1 = 2'd2,
    FAULT_FLIP_L2 = 2'd3
  } fault_e;

  typedef struct packed {
    logic pp;
    logic l0;
    logic l1;
    logic l2;
    logic acc;
    logic long_seq;
  } seq_plan_t;

  function automatic seq_plan_t plan_sequence(input seq_kind_e kind, input fault_e fault,
                                              input logic fault_en);
    seq_plan_t p;
    p = '0;
    case (kind)
      KIND_FULL_ACC:    begin p.l0 = 1'b1; p.l1 = 1'b1; p.l2 = 1'b1; p.acc = 1'b1; end
      KIND_FULL_REJ:    begin p.l0 = 1'b1; p.l1 = 1'b1; p.l2 = 1'b1; end
      KIND_PP_FULL_ACC: begin p.pp = 1'b1; p.l0 = 1'b1; p.l1 = 1'b1; p.l2 = 1'b1; p.acc = 1'b1; end
      KIND_PP_FULL_REJ: begin p.pp = 1'b1; p.l0 = 1'b1; p.l1 = 1'b1; p.l2 = 1'b1; end
      KIND_L1_REJ:      p.l0 = 1'b1;
      KIND_PP_L1_REJ:   begin p.pp = 1'b1; p.l0 = 1'b1; end
      KIND_PP_ONLY:     p.pp = 1'b1;
      default:          p = '0;
    endcase
    p.long_seq = p.l2;
    if (fault_en && p.long_seq) begin
      case (fault)
        FAULT_DROP_L2: p.l2 = 1'b0;
        FAULT_DROP_L1: p.l1 = 1'b0;
        FAULT_FLIP_L2: p.acc = ~p.acc;
        default:       p.acc = p.acc;
      endcase
    end
    return p;
  endfunction

  // Galois form, polynomial x^32 + x^22 + x^2 + x + 1
  function automatic logic [31:0] lfsr_step(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? 32'h8020_0003 : 32'h0);
  endfunction

endpackage

// File: rtl/tse_start_gen.sv
module tse_start_gen #(
  parameter int DIVW = 16,
  parameter logic [31:0] SEED = 32'h1234_5679
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      src_en,
  input  logic [DIVW-1:0] div_period,
  input  logic [31:0]     rnd_thresh,
  input  logic            ext_pulse,
  input  logic            sw_req,
  output logic            start
);
  import tse_pkg::*;

  logic [DIVW-1:0] div_cnt_q;
  logic [31:0]     lfsr_q;
  logic            ext_q;
  logic            div_tick, rnd_hit, ext_rise;

  assign div_tick = (div_period != '0) && (div_cnt_q >= div_period - DIVW'(1));
  assign rnd_hit  = lfsr_q < rnd_thresh;
  assign ext_rise = ext_pulse && !ext_q;
  assign start    = |(src_en & {sw_req, ext_rise, rnd_hit, div_tick});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt_q <= '0;
      lfsr_q    <= SEED;
      ext_q     <= 1'b0;
    end else begin
      div_cnt_q <= div_tick || (div_period == '0) ? '0 : div_cnt_q + DIVW'(1);
      lfsr_q    <= lfsr_step(lfsr_q);
      ext_q     <= ext_pulse;
    end
  end

  // R3: a divider longer than one cycle never ticks twice in a row
  assert_div_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (div_tick && div_period > DIVW'(1) && $stable(div_period)) |=> !div_tick);

endmodule

// File: rtl/tse_prog_store.sv
module tse_prog_store #(
  parameter int DEPTH = 32,
  parameter int EW    = 37,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [EW-1:0] wdata,
  input  logic [AW:0]   prog_len,
  input  logic          advance,
  output logic [EW-1:0] entry,
  output logic [AW-1:0] idx
);
  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] idx_q;

  function automatic logic [AW-1:0] wrap_next(input logic [AW-1:0] i, input logic [AW:0] len);
    logic [AW:0] nxt;
    nxt = {1'b0, i} + (AW+1)'(1);
    if (nxt >= len) return '0;
    return nxt[AW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       idx_q <= '0;
    else if (advance) idx_q <= wrap_next(idx_q, prog_len);
  end

  assign entry = mem[idx_q];
  assign idx   = idx_q;

endmodule

// File: rtl/tse_player.sv
module tse_player #(
  parameter int TW  = 12,
  parameter int L1W = 16,
  parameter int L2W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  tse_pkg::seq_kind_e kind,
  input  tse_pkg::fault_e   fault,
  input  logic              fault_en,
  input  logic [L1W-1:0]    l1_word,
  input  logic [L2W-1:0]    l2_word,
  input  logic [TW-1:0]     lat_l0,
  input  logic [TW-1:0]     lat_l1,
  input  logic [TW-1:0]     lat_l2,
  output logic              accept,
  output logic              busy_o,
  output logic              pp_o,
  output logic              l0_o,
  output logic              l1_o,
  output logic [L1W-1:0]    l1_data_o,
  output logic              l2_stb_o,
  output logic              l2_acc_o,
  output logic [L2W-1:0]    l2_data_o
);
  import tse_pkg::*;

  logic           busy_q, saw_l0_q;
  logic [TW-1:0]  tmr_q, end_q;
  seq_plan_t      plan_q, plan_new;
  logic [L1W-1:0] l1w_q;
  logic [L2W-1:0] l2w_q;
  logic           hit_pp, hit_l0, hit_l1, hit_l2;

  assign plan_new = plan_sequence(kind, fault, fault_en);
  assign accept   = start && !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tmr_q  <= '0;
      end_q  <= '0;
      plan_q <= '0;
      l1w_q  <= '0;
      l2w_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      tmr_q  <= '0;
      end_q  <= plan_new.long_seq ? lat_l2 : lat_l1;
      plan_q <= plan_new;
      l1w_q  <= l1_word;
      l2w_q  <= l2_word;
    end else if (busy_q) begin
      if (tmr_q == end_q) busy_q <= 1'b0;
      else                tmr_q  <= tmr_q + TW'(1);
    end
  end

  assign hit_pp = busy_q && (tmr_q == '0)    && plan_q.pp;
  assign hit_l0 = busy_q && (tmr_q == lat_l0) && plan_q.l0;
  assign hit_l1 = busy_q && (tmr_q == lat_l1) && plan_q.l1;
  assign hit_l2 = busy_q && (tmr_q == lat_l2) && plan_q.l2;

  // tracks whether this sequence has already issued its level-0
  always_ff @(posedge clk) begin
    if (!rst_n)      saw_l0_q <= 1'b0;
    else if (accept) saw_l0_q <= 1'b0;
    else if (hit_l0) saw_l0_q <= 1'b1;
  end

  assign busy_o    = busy_q;
  assign pp_o      = hit_pp;
  assign l0_o      = hit_l0;
  assign l1_o      = hit_l1;
  assign l1_data_o = hit_l1 ? l1w_q : '0;
  assign l2_stb_o  = hit_l2;
  assign l2_acc_o  = hit_l2 && plan_q.acc;
  assign l2_data_o = hit_l2 ? l2w_q : '0;

  assert_pulse_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pp_o, l0_o, l1_o, l2_stb_o}));

  assert_l0_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    l0_o |=> !l0_o);

  assert_l1_after_l0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    l1_o |-> saw_l0_q);

  assert_l2_after_l0_R9: assert property (@(posedge clk) disable iff (!rst_n)
    l2_stb_o |-> saw_l0_q);

  assert_accept_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy_o && tmr_q == '0));

endmodule

// File: rtl/trig_seq_emulator.sv
module trig_seq_emulator #(
  parameter int DEPTH = 32,
  parameter int L1W   = 16,
  parameter int L2W   = 16,
  parameter int TW    = 12,
  parameter int DIVW  = 16,
  parameter int CW    = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int EW   = 5 + L1W + L2W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            prog_we,
  input  logic [AW-1:0]   prog_addr,
  input  logic [EW-1:0]   prog_wdata,
  input  logic [AW:0]     prog_len,
  input  logic [3:0]      src_en,
  input  logic [DIVW-1:0] div_period,
  input  logic [31:0]     rnd_thresh,
  input  logic            ext_pulse,
  input  logic            sw_req,
  input  logic            err_en,
  input  logic [TW-1:0]   lat_l0,
  input  logic [TW-1:0]   lat_l1,
  input  logic [TW-1:0]   lat_l2,
  output logic            pp_o,
  output logic            l0_o,
  output logic            l1_o,
  output logic [L1W-1:0]  l1_data_o,
  output logic            l2_stb_o,
  output logic            l2_acc_o,
  output logic [L2W-1:0]  l2_data_o,
  output logic            busy_o,
  output logic [CW-1:0]   drop_cnt_o
);
  import tse_pkg::*;

  logic          start, accept;
  logic [EW-1:0] entry;
  logic [AW-1:0] idx;
  logic [CW-1:0] drop_q;

  tse_start_gen #(.DIVW(DIVW)) u_start (
    .clk(clk), .rst_n(rst_n), .src_en(src_en), .div_period(div_period),
    .rnd_thresh(rnd_thresh), .ext_pulse(ext_pulse), .sw_req(sw_req), .start(start)
  );

  tse_prog_store #(.DEPTH(DEPTH), .EW(EW)) u_store (
    .clk(clk), .rst_n(rst_n), .we(prog_we), .waddr(prog_addr), .wdata(prog_wdata),
    .prog_len(prog_len), .advance(accept), .entry(entry), .idx(idx)
  );

  tse_player #(.TW(TW), .L1W(L1W), .L2W(L2W)) u_player (
    .clk(clk), .rst_n(rst_n), .start(start),
    .kind(seq_kind_e'(entry[2:0])), .fault(fault_e'(entry[4:3])), .fault_en(err_en),
    .l1_word(entry[5 +: L1W]), .l2_word(entry[5+L1W +: L2W]),
    .lat_l0(lat_l0), .lat_l1(lat_l1), .lat_l2(lat_l2),
    .accept(accept), .busy_o(busy_o), .pp_o(pp_o), .l0_o(l0_o), .l1_o(l1_o),
    .l1_data_o(l1_data_o), .l2_stb_o(l2_stb_o), .l2_acc_o(l2_acc_o), .l2_data_o(l2_data_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) drop_q <= '0;
    else if (start && busy_o && drop_q != '1) drop_q <= drop_q + CW'(1);
  end

  assign drop_cnt_o = drop_q;

  assert_drop_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy_o && drop_q != '1) |=> drop_cnt_o == $past(drop_cnt_o) + CW'(1));

  assert_index_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy_o) |=> $stable(idx));

endmodule

// File: tb/tb_trig_seq_emulator.sv
module tb_trig_seq_emulator;
  localparam int LAT0 = 3, LAT1 = 7, LAT2 = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic prog_we = 1'b0;
  logic [4:0] prog_addr = '0;
  logic [36:0] prog_wdata = '0;
  logic [5:0] prog_len = 6'd1;
  logic [3:0] src_en = 4'b1000;
  logic [15:0] div_period = '0;
  logic [31:0] rnd_thresh = '0;
  logic ext_pulse = 1'b0, sw_req = 1'b0, err_en = 1'b0;
  logic [11:0] lat_l0 = 12'(LAT0), lat_l1 = 12'(LAT1), lat_l2 = 12'(LAT2);
  logic pp_o, l0_o, l1_o, l2_stb_o, l2_acc_o, busy_o;
  logic [15:0] l1_data_o, l2_data_o, drop_cnt_o;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  trig_seq_emulator dut (.*);

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_entry(input int a, input int kind, input int fault, input logic [15:0] w1,
                          input logic [15:0] w2);
    @(negedge clk);
    prog_we = 1'b1; prog_addr = 5'(a);
    prog_wdata = {w2, w1, 2'(fault), 3'(kind)};
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  // one software start, full comparison of every cycle of the window
  task automatic run_sweep(input int kind, input int fault, input int en,
                           input logic [15:0] w1, input logic [15:0] w2);
    bit has_pp, has_l0, has_l1, has_l2, acc, longs;
    int t0, last;
    logic [63:0] ev, av;
    has_l1 = kind < 4; has_l2 = kind < 4; longs = kind < 4;
    has_l0 = kind < 6;
    has_pp = (kind == 2) || (kind == 3) || (kind == 5) || (kind == 6);
    acc = (kind == 0) || (kind == 2);
    if (en != 0 && longs) begin
      if (fault == 1) has_l2 = 0;
      if (fault == 2) has_l1 = 0;
      if (fault == 3) acc = !acc;
    end
    last = longs ? LAT2 : LAT1;
    @(negedge clk);
    sw_req = 1'b1; t0 = cyc + 1;
    for (int i = 0; i <= last + 1; i++) begin
      @(negedge clk);
      sw_req = 1'b0;
      ev = {26'd0, 1'(i <= last), 1'(has_pp && i == 0), 1'(has_l0 && i == LAT0),
            1'(has_l1 && i == LAT1), 1'(has_l2 && i == LAT2), 1'(has_l2 && acc && i == LAT2),
            (has_l1 && i == LAT1) ? w1 : 16'h0, (has_l2 && i == LAT2) ? w2 : 16'h0};
      av = {26'd0, busy_o, pp_o, l0_o, l1_o, l2_stb_o, l2_acc_o, l1_data_o, l2_data_o};
      chk(av == ev && (cyc - t0) == i,
          $sformatf("R4 R5 R6 R7 R9 R10 kind=%0d err=%0d en=%0d off=%0d", kind, fault, en, i),
          av, ev);
    end
  endtask

  // software start with optional extra requests during the run
  task automatic fire_watch(input int x1, input int x2, output int n_l0, output int l0_off,
                            output logic [15:0] l1seen);
    int t0, off;
    n_l0 = 0; l0_off = -1; l1seen = '0;
    @(negedge clk);
    sw_req = 1'b1; t0 = cyc + 1;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      off = cyc - t0;
      sw_req = (off == x1) || (off == x2);
      if (l0_o) begin n_l0++; if (l0_off < 0) l0_off = off; end
      if (l1_o) l1seen = l1_data_o;
    end
    sw_req = 1'b0;
  endtask

  // counts level-0 pulses and records the cycles of the first three
  task automatic watch_l0(input int win, output int n, output int c0, output int c1, output int c2);
    n = 0; c0 = 0; c1 = 0; c2 = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (l0_o) begin
        if (n == 0) c0 = cyc;
        if (n == 1) c1 = cyc;
        if (n == 2) c2 = cyc;
        n++;
      end
    end
  endtask

  task automatic drain();
    repeat (20) @(negedge clk);
  endtask

  initial begin
    int n, c0, c1, c2, off;
    logic [15:0] seen, d0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk({busy_o, pp_o, l0_o, l1_o, l2_stb_o, l2_acc_o, l1_data_o, l2_data_o, drop_cnt_o} == '0,
        "R1 reset state", {busy_o, pp_o, l0_o, l1_o, l2_stb_o, l2_acc_o, l1_data_o, l2_data_o,
        drop_cnt_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 R6 R9 R10: every kind, every error field, error enable off and on
    for (int en = 0; en < 2; en++) begin
      err_en = 1'(en);
      for (int k = 0; k < 8; k++) begin
        for (int e = 0; e < 4; e++) begin
          wr_entry(0, k, e, 16'h1000 + 16'(en * 32 + k * 4 + e), 16'h2000 + 16'(en * 32 + k * 4 + e));
          run_sweep(k, e, en, 16'h1000 + 16'(en * 32 + k * 4 + e), 16'h2000 + 16'(en * 32 + k * 4 + e));
        end
      end
    end
    err_en = 1'b0;
    chk(drop_cnt_o == 0, "R8 no drops in sweep", 64'(drop_cnt_o), 0);

    // R3: software request ignored when its enable bit is clear
    src_en = 4'b0111;
    @(negedge clk); sw_req = 1'b1;
    @(negedge clk); sw_req = 1'b0;
    watch_l0(20, n, c0, c1, c2);
    chk(n == 0 && busy_o == 1'b0, "R3 masked software start", 64'(n), 0);
    src_en = 4'b1000;

    // R2: index order and wrap with three entries
    for (int a = 0; a < 3; a++) wr_entry(a, 0, 0, 16'hA000 + 16'(a), 16'hB000);
    prog_len = 6'd3;
    for (int r = 0; r < 4; r++) begin
      fire_watch(-1, -1, n, off, seen);
      chk(seen == 16'hA000 + 16'(r % 3), "R2 program index order", 64'(seen), 64'(16'hA000 + 16'(r % 3)));
    end

    // R8: starts during busy are dropped, counted, and leave index and timing alone
    d0 = drop_cnt_o;
    fire_watch(2, 5, n, off, seen);
    chk(n == 1 && off == LAT0, "R8 running sequence undisturbed", 64'(off), 64'(LAT0));
    chk(seen == 16'hA001, "R8 dropped start runs entry 1", 64'(seen), 64'hA001);
    chk(drop_cnt_o == d0 + 16'd2, "R8 drop count", 64'(drop_cnt_o), 64'(d0 + 16'd2));
    fire_watch(-1, -1, n, off, seen);
    chk(seen == 16'hA002, "R8 index not advanced by drops", 64'(seen), 64'hA002);

    // R3: divider source gives one start every period
    div_period = 16'd20; src_en = 4'b0001;
    watch_l0(90, n, c0, c1, c2);
    chk(n >= 4 && (c1 - c0) == 20 && (c2 - c1) == 20, "R3 divider spacing", 64'(c1 - c0), 64'd20);
    src_en = 4'b0000; div_period = '0; drain();

    // R3: random source, threshold 0 never, full threshold often
    src_en = 4'b0010; rnd_thresh = '0;
    watch_l0(100, n, c0, c1, c2);
    chk(n == 0, "R3 random threshold zero", 64'(n), 0);
    rnd_thresh = '1;
    watch_l0(100, n, c0, c1, c2);
    chk(n >= 5, "R3 random threshold full", 64'(n), 5);
    src_en = 4'b0000; rnd_thresh = '0; drain();

    // R3: external pulser held high gives a single start, no drop
    d0 = drop_cnt_o;
    src_en = 4'b0100; ext_pulse = 1'b1;
    watch_l0(40, n, c0, c1, c2);
    chk(n == 1, "R3 external edge single start", 64'(n), 1);
    chk(drop_cnt_o == d0, "R3 external level no drops", 64'(drop_cnt_o), 64'(d0));
    ext_pulse = 1'b0; src_en = 4'b1000; drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule